// File: doc/BRIEF.md
# Four-Channel Prescaled Match Timer

This peripheral holds four 32-bit counters that share a single programmable clock divider. Each counter has its own run bit, its own hold-at-zero bit and its own count direction. Each counter is paired with one compare register. When a counter steps onto its compare value, a status flag is raised. Per channel, the match can also forward the flag to the interrupt line, reload the counter to zero on the following divided tick, or stop the channel.

Software reaches every register through a small synchronous register bus. Address bits 7:4 select the register. Address bits 3:2 select how a write is applied:
- 0: replace the register.
- 1: OR the written bits in.
- 2: clear the written bits.
- 3: invert the written bits.

Reads return the same register whatever the access mode. The single interrupt output is high while any flag whose interrupt enable is set is high.

Top module: `quad_match_timer`

Register offsets (mode bits zero): status 0x00, control 0x10, direction 0x20, counters 0x30/0x40/0x50/0x60 (channel 0..3), divider 0x70, divider count 0x80, match actions 0x90, compare registers 0xA0/0xB0/0xC0/0xD0 (channel 0..3).

## Requirements
- R1: A write to a register applies the data according to the access mode in address bits 3:2. Mode 0 replaces the register, 1 ORs the data in, 2 clears the data bits and 3 inverts the data bits. This is shown on the compare register at 0xA0.
- R2: In control (0x10), bit n (n = 0..3) runs counter n and bit 4+n holds it. While a hold bit is set, that counter and the shared divider count read zero from the clock edge after the write. Counting resumes once the bit is cleared.
- R3: Direction (0x20) keeps one bit per channel at bit 4n, where 0 counts up and 1 counts down. Other bits read zero, and the reset value is zero.
- R4: With divider value P at 0x70, a running counter steps once every P+1 clocks, and P = 0 steps it every clock. The divider count at 0x80 shows the position within the period, from 0 to P.
- R5: When counter n steps onto the value of compare register n, status bit n (0x00) is set at that edge. The interrupt output is the OR of the status bits whose enable bit 3n at 0x90 is set.
- R6: With bit 3n+1 at 0x90 set, counter n loads zero on the divided tick after the one that reached the compare value.
- R7: With bit 3n+2 at 0x90 set, a match clears run bit n in control at the same edge, and the counter keeps the matched value.
- R8: A counter that wraps between 0xFFFFFFFF and 0 sets no status bit, unless the value it lands on equals its compare value.
- R9: At 0x00, writing 1s in mode 0 or mode 2 clears those status bits, mode 1 sets them and mode 3 inverts them. Status bit 4 always reads zero.
- R10: The counter registers are read-only, so a write to them in any mode leaves their value unchanged.
- R11: After reset, every register reads zero and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWr | input | 1 | Write strobe for the current address |
| busAddr | input | ADDR_W (8) | Register byte address; bits 3:2 give the access mode |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The situation that is hardest to reach is a counter wrapping from zero down to all ones. Counting up to the wrap would take 2^32 ticks, and the counters cannot be preset. The bench therefore sets the direction bit, clears the channel through its hold bit and releases it with the divider at zero. The wrap then happens on the first step, with every interrupt enable set, so any spurious flag would show on the interrupt pin. The timing of the reload-on-match and stop-on-match actions is checked at exact clock counts after the run bit is released.

// File: rtl/qmt_pkg.sv
package qmt_pkg;

  localparam int QMT_CH     = 4;
  localparam int BUS_W      = 32;
  localparam int REG_IDX_W  = 4;
  localparam int DIR_STRIDE = 4;

  typedef enum logic [1:0] {
    ACC_WRITE  = 2'd0,
    ACC_OR     = 2'd1,
    ACC_ANDNOT = 2'd2,
    ACC_XOR    = 2'd3
  } accMode_e;

  localparam int IDX_STATUS = 0;
  localparam int IDX_CTRL   = 1;
  localparam int IDX_DIR    = 2;
  localparam int IDX_CNT    = 3;
  localparam int IDX_DIV    = 7;
  localparam int IDX_DIVCNT = 8;
  localparam int IDX_ACTION = 9;
  localparam int IDX_CMP    = 10;

  typedef struct packed {
    logic [QMT_CH-1:0] runEn;
    logic [QMT_CH-1:0] holdZero;
    logic [QMT_CH-1:0] countDown;
    logic [QMT_CH-1:0] reloadOnMatch;
  } chanCtrl_t;

  function automatic logic [BUS_W-1:0] applyAccess(
    input accMode_e mode,
    input logic [BUS_W-1:0] cur,
    input logic [BUS_W-1:0] wd
  );
    case (mode)
      ACC_OR:     return cur | wd;
      ACC_ANDNOT: return cur & ~wd;
      ACC_XOR:    return cur ^ wd;
      default:    return wd;
    endcase
  endfunction

endpackage

// File: rtl/qmt_lane.sv
module qmt_lane #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             runEn,
  input  logic             holdZero,
  input  logic             countDown,
  input  logic             reloadOnMatch,
  input  logic [CNT_W-1:0] cmpVal,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);

  logic             step;
  logic             atCmp;
  logic [CNT_W-1:0] nextVal;

  assign step  = tick && runEn && !holdZero;
  assign atCmp = (cnt == cmpVal);

  always_comb begin
    if (reloadOnMatch && atCmp)
      nextVal = '0;
    else if (countDown)
      nextVal = cnt - CNT_W'(1);
    else
      nextVal = cnt + CNT_W'(1);
  end

  assign hit = step && (nextVal == cmpVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      cnt <= '0;
    else if (holdZero)
      cnt <= '0;
    else if (step)
      cnt <= nextVal;
  end

endmodule

// File: rtl/qmt_core.sv
module qmt_core
  import qmt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PRE_W = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  chanCtrl_t                    strb,
  input  logic [PRE_W-1:0]             preDiv,
  input  logic [QMT_CH-1:0][CNT_W-1:0] cmpVal,
  output logic [QMT_CH-1:0][CNT_W-1:0] cntVal,
  output logic [PRE_W-1:0]             preCnt,
  output logic [QMT_CH-1:0]            chanHit
);

  logic anyRun;
  logic anyHold;
  logic tick;

  assign anyRun  = |strb.runEn;
  assign anyHold = |strb.holdZero;
  assign tick    = anyRun && !anyHold && (preCnt >= preDiv);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      preCnt <= '0;
    else if (anyHold)
      preCnt <= '0;
    else if (anyRun)
      preCnt <= tick ? '0 : preCnt + PRE_W'(1);
  end

  for (genvar n = 0; n < QMT_CH; n++) begin : gLane
    qmt_lane #(.CNT_W(CNT_W)) uLane (
      .clk          (clk),
      .rstN         (rstN),
      .tick         (tick),
      .runEn        (strb.runEn[n]),
      .holdZero     (strb.holdZero[n]),
      .countDown    (strb.countDown[n]),
      .reloadOnMatch(strb.reloadOnMatch[n]),
      .cmpVal       (cmpVal[n]),
      .cnt          (cntVal[n]),
      .hit          (chanHit[n])
    );
  end

endmodule

// File: rtl/qmt_regs.sv
module qmt_regs
  import qmt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int PRE_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         busWr,
  input  logic [ADDR_W-1:0]            busAddr,
  input  logic [BUS_W-1:0]             busWdata,
  output logic [BUS_W-1:0]             busRdata,
  output logic                         irq,
  input  logic [QMT_CH-1:0]            chanHit,
  input  logic [QMT_CH-1:0][CNT_W-1:0] cntVal,
  input  logic [PRE_W-1:0]             preCnt,
  output chanCtrl_t                    strb,
  output logic [PRE_W-1:0]             preDiv,
  output logic [QMT_CH-1:0][CNT_W-1:0] cmpVal,
  output logic [QMT_CH-1:0]            flagVec,
  output logic [QMT_CH-1:0]            intEnVec,
  output logic [QMT_CH-1:0]            stopEnVec
);

  localparam int CTRL_W = 2 * QMT_CH;
  localparam int ACT_W  = 3 * QMT_CH;

  logic [CTRL_W-1:0]  ctrlReg, ctrlNext;
  logic [QMT_CH-1:0]  dirReg, dirNext;
  logic [ACT_W-1:0]   actReg, actNext;
  logic [PRE_W-1:0]   divReg, divNext;
  logic [QMT_CH-1:0]  flagReg, flagNext;
  logic [QMT_CH-1:0][CNT_W-1:0] cmpReg, cmpNext;

  logic [REG_IDX_W-1:0] regIdx;
  accMode_e             mode;
  logic                 inRange;
  logic                 wrEn;
  logic [BUS_W-1:0]     dirImg;
  logic [BUS_W-1:0]     ctrlImg, dirNewImg, actImg, divImg, flagImg, cmpImg;
  logic [QMT_CH-1:0]    reloadVec;

  assign regIdx  = busAddr[7:4];
  assign mode    = accMode_e'(busAddr[3:2]);
  assign inRange = ((busAddr >> 8) == '0);
  assign wrEn    = busWr && inRange;

  always_comb begin
    dirImg = '0;
    for (int n = 0; n < QMT_CH; n++)
      dirImg[DIR_STRIDE*n] = dirReg[n];
  end

  always_comb begin
    for (int n = 0; n < QMT_CH; n++) begin
      intEnVec[n]  = actReg[3*n];
      reloadVec[n] = actReg[3*n+1];
      stopEnVec[n] = actReg[3*n+2];
    end
  end

  always_comb begin
    ctrlImg   = applyAccess(mode, BUS_W'(ctrlReg), busWdata);
    dirNewImg = applyAccess(mode, dirImg, busWdata);
    actImg    = applyAccess(mode, BUS_W'(actReg), busWdata);
    divImg    = applyAccess(mode, BUS_W'(divReg), busWdata);
    flagImg   = BUS_W'(flagReg);
    case (mode)
      ACC_OR:  flagImg = BUS_W'(flagReg) | busWdata;
      ACC_XOR: flagImg = BUS_W'(flagReg) ^ busWdata;
      default: flagImg = BUS_W'(flagReg) & ~busWdata;
    endcase

    ctrlNext = ctrlReg;
    dirNext  = dirReg;
    actNext  = actReg;
    divNext  = divReg;
    flagNext = flagReg;
    cmpNext  = cmpReg;
    cmpImg   = '0;

    if (wrEn) begin
      if (regIdx == REG_IDX_W'(IDX_CTRL))   ctrlNext = ctrlImg[CTRL_W-1:0];
      if (regIdx == REG_IDX_W'(IDX_ACTION)) actNext  = actImg[ACT_W-1:0];
      if (regIdx == REG_IDX_W'(IDX_DIV))    divNext  = divImg[PRE_W-1:0];
      if (regIdx == REG_IDX_W'(IDX_STATUS)) flagNext = flagImg[QMT_CH-1:0];
      if (regIdx == REG_IDX_W'(IDX_DIR)) begin
        for (int n = 0; n < QMT_CH; n++)
          dirNext[n] = dirNewImg[DIR_STRIDE*n];
      end
      for (int n = 0; n < QMT_CH; n++) begin
        if (regIdx == REG_IDX_W'(IDX_CMP + n)) begin
          cmpImg     = applyAccess(mode, BUS_W'(cmpReg[n]), busWdata);
          cmpNext[n] = cmpImg[CNT_W-1:0];
        end
      end
    end

    // hardware events take priority over a simultaneous bus write
    for (int n = 0; n < QMT_CH; n++) begin
      if (chanHit[n]) begin
        flagNext[n] = 1'b1;
        if (stopEnVec[n]) ctrlNext[n] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      dirReg  <= '0;
      actReg  <= '0;
      divReg  <= '0;
      flagReg <= '0;
      cmpReg  <= '0;
    end else begin
      ctrlReg <= ctrlNext;
      dirReg  <= dirNext;
      actReg  <= actNext;
      divReg  <= divNext;
      flagReg <= flagNext;
      cmpReg  <= cmpNext;
    end
  end

  always_comb begin
    busRdata = '0;
    if (inRange) begin
      case (regIdx)
        REG_IDX_W'(IDX_STATUS): busRdata = BUS_W'(flagReg);
        REG_IDX_W'(IDX_CTRL):   busRdata = BUS_W'(ctrlReg);
        REG_IDX_W'(IDX_DIR):    busRdata = dirImg;
        REG_IDX_W'(IDX_DIV):    busRdata = BUS_W'(divReg);
        REG_IDX_W'(IDX_DIVCNT): busRdata = BUS_W'(preCnt);
        REG_IDX_W'(IDX_ACTION): busRdata = BUS_W'(actReg);
        default: begin
          for (int n = 0; n < QMT_CH; n++) begin
            if (regIdx == REG_IDX_W'(IDX_CNT + n)) busRdata = BUS_W'(cntVal[n]);
            if (regIdx == REG_IDX_W'(IDX_CMP + n)) busRdata = BUS_W'(cmpReg[n]);
          end
        end
      endcase
    end
  end

  assign irq                = |(flagReg & intEnVec);
  assign strb.runEn         = ctrlReg[QMT_CH-1:0];
  assign strb.holdZero      = ctrlReg[CTRL_W-1:QMT_CH];
  assign strb.countDown     = dirReg;
  assign strb.reloadOnMatch = reloadVec;
  assign preDiv             = divReg;
  assign cmpVal             = cmpReg;
  assign flagVec            = flagReg;

endmodule

// File: rtl/quad_match_timer.sv
module quad_match_timer
  import qmt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int PRE_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  output logic              irq
);

  chanCtrl_t                    strb;
  logic [PRE_W-1:0]             preDiv;
  logic [PRE_W-1:0]             preCnt;
  logic [QMT_CH-1:0][CNT_W-1:0] cmpVal;
  logic [QMT_CH-1:0][CNT_W-1:0] cntVal;
  logic [QMT_CH-1:0]            chanHit;
  logic [QMT_CH-1:0]            flagVec;
  logic [QMT_CH-1:0]            intEnVec;
  logic [QMT_CH-1:0]            stopEnVec;

  qmt_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W), .ADDR_W(ADDR_W)) uRegs (
    .clk      (clk),
    .rstN     (rstN),
    .busWr    (busWr),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .irq      (irq),
    .chanHit  (chanHit),
    .cntVal   (cntVal),
    .preCnt   (preCnt),
    .strb     (strb),
    .preDiv   (preDiv),
    .cmpVal   (cmpVal),
    .flagVec  (flagVec),
    .intEnVec (intEnVec),
    .stopEnVec(stopEnVec)
  );

  qmt_core #(.CNT_W(CNT_W), .PRE_W(PRE_W)) uCore (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .preDiv (preDiv),
    .cmpVal (cmpVal),
    .cntVal (cntVal),
    .preCnt (preCnt),
    .chanHit(chanHit)
  );

endmodule

// File: rtl/qmt_checker.sv
module qmt_checker
  import qmt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         irq,
  input logic [QMT_CH-1:0]            runEn,
  input logic [QMT_CH-1:0]            holdZero,
  input logic [QMT_CH-1:0][CNT_W-1:0] cntVal,
  input logic [QMT_CH-1:0]            chanHit,
  input logic [QMT_CH-1:0]            flagVec,
  input logic [QMT_CH-1:0]            intEnVec,
  input logic [QMT_CH-1:0]            stopEnVec
);

  for (genvar n = 0; n < QMT_CH; n++) begin : gChk
    assert_hold_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
      $past(holdZero[n]) |-> (cntVal[n] == '0));

    assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
      (!$past(runEn[n]) && !$past(holdZero[n])) |-> $stable(cntVal[n]));

    assert_stop_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
      (chanHit[n] && stopEnVec[n]) |=> !runEn[n]);

    assert_flag_on_hit_R5: assert property (@(posedge clk) disable iff (!rstN)
      chanHit[n] |=> flagVec[n]);
  end

  assert_irq_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((flagVec & intEnVec) == '0) |-> !irq);

endmodule

bind quad_match_timer qmt_checker #(.CNT_W(CNT_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .irq      (irq),
  .runEn    (strb.runEn),
  .holdZero (strb.holdZero),
  .cntVal   (cntVal),
  .chanHit  (chanHit),
  .flagVec  (flagVec),
  .intEnVec (intEnVec),
  .stopEnVec(stopEnVec)
);

// File: tb/tb_quad_match_timer.sv
module tb_quad_match_timer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  quad_match_timer dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    busAddr = a;
    #1;
    v = busRdata;
  endtask

  task automatic waitCycles(input int k);
    repeat (k) @(negedge clk);
  endtask

  // hold all channels, program, then release the given run mask
  task automatic setup(input logic [31:0] div, input logic [31:0] act,
                       input logic [31:0] dir, input logic [31:0] runMask);
    wr(8'h10, 32'hF0);
    wr(8'h70, div);
    wr(8'h90, act);
    wr(8'h20, dir);
    wr(8'h00, 32'hF);
    wr(8'h10, runMask);
  endtask

  task automatic testReset();
    logic [31:0] v;
    foreach (v[i]) ;
    for (int a = 0; a < 14; a++) begin
      rd(8'(a << 4), v);
      check($sformatf("R11 reg 0x%02h after reset", a << 4), v, 32'h0);
    end
    check("R11 irq after reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic testAlias();
    logic [31:0] v;
    wr(8'hA0, 32'h0F0F); rd(8'hA0, v); check("R1 plain write", v, 32'h0F0F);
    wr(8'hA4, 32'hF000); rd(8'hA0, v); check("R1 or mode", v, 32'hFF0F);
    wr(8'hA8, 32'h000F); rd(8'hA0, v); check("R1 clear mode", v, 32'hFF00);
    wr(8'hAC, 32'h0FF0); rd(8'hAC, v); check("R1 toggle mode", v, 32'hF0F0);
  endtask

  task automatic testDir();
    logic [31:0] v;
    wr(8'h20, 32'h3333); rd(8'h20, v);
    check("R3 direction field bits", v, 32'h1111);
    wr(8'h20, 32'h0);
  endtask

  task automatic testHold();
    logic [31:0] v;
    wr(8'h70, 32'd3);
    wr(8'h10, 32'h11);
    waitCycles(6);
    rd(8'h30, v); check("R2 counter held", v, 32'h0);
    rd(8'h80, v); check("R2 divider count held", v, 32'h0);
    wr(8'h10, 32'h01);
    waitCycles(4);
    rd(8'h30, v); check("R2 counting after release", v, 32'h1);
  endtask

  task automatic testPrescale();
    logic [31:0] v;
    setup(32'd2, 32'h0, 32'h0, 32'h1);
    waitCycles(9);
    rd(8'h30, v); check("R4 divide by 3", v, 32'd3);
    waitCycles(1);
    rd(8'h80, v); check("R4 divider count", v, 32'd1);
    setup(32'd0, 32'h0, 32'h0, 32'h1);
    waitCycles(5);
    rd(8'h30, v); check("R4 divider zero", v, 32'd5);
  endtask

  task automatic testMatchIrq();
    logic [31:0] v;
    wr(8'hA0, 32'd4);
    setup(32'd0, 32'h1, 32'h0, 32'h1);
    waitCycles(3);
    rd(8'h00, v); check("R5 flag before match", v, 32'h0);
    waitCycles(1);
    rd(8'h00, v); check("R5 flag at match", v, 32'h1);
    check("R5 irq at match", {31'b0, irq}, 32'h1);
    wr(8'h10, 32'h0);
    wr(8'h00, 32'h1);
    rd(8'h00, v); check("R9 plain write clears flag", v, 32'h0);
    check("R9 irq low after clear", {31'b0, irq}, 32'h0);
  endtask

  task automatic testReload();
    logic [31:0] v;
    wr(8'hB0, 32'd2);
    setup(32'd0, 32'h10, 32'h0, 32'h2);
    waitCycles(2);
    rd(8'h40, v); check("R6 at compare value", v, 32'd2);
    waitCycles(1);
    rd(8'h40, v); check("R6 reloaded to zero", v, 32'd0);
    waitCycles(2);
    rd(8'h40, v); check("R6 second period", v, 32'd2);
    rd(8'h00, v); check("R5 flag channel 1 without irq enable", v, 32'h2);
    check("R5 irq masked", {31'b0, irq}, 32'h0);
  endtask

  task automatic testStop();
    logic [31:0] v;
    wr(8'hC0, 32'd3);
    setup(32'd0, 32'h100, 32'h0, 32'h4);
    waitCycles(3);
    rd(8'h50, v); check("R7 counter at match", v, 32'd3);
    rd(8'h10, v); check("R7 run bit cleared", v, 32'h0);
    waitCycles(5);
    rd(8'h50, v); check("R7 counter stays", v, 32'd3);
  endtask

  task automatic testReadOnly();
    logic [31:0] v;
    wr(8'h50, 32'hABC); wr(8'h54, 32'hFFFF); wr(8'h58, 32'h3); wr(8'h5C, 32'h7);
    rd(8'h50, v); check("R10 counter ignores writes", v, 32'd3);
  endtask

  task automatic testWrap();
    logic [31:0] v;
    wr(8'hD0, 32'h10);
    setup(32'd0, 32'hFFF, 32'h1000, 32'h8);
    waitCycles(1);
    rd(8'h60, v); check("R3 down wrap", v, 32'hFFFF_FFFF);
    waitCycles(2);
    rd(8'h60, v); check("R3 counting down", v, 32'hFFFF_FFFD);
    rd(8'h00, v); check("R8 no flag on wrap", v, 32'h0);
    check("R8 irq low on wrap", {31'b0, irq}, 32'h0);
    wr(8'h10, 32'h0);
  endtask

  task automatic testFlagModes();
    logic [31:0] v;
    wr(8'h90, 32'h8);
    wr(8'h04, 32'h12); rd(8'h00, v); check("R9 or mode sets flag", v, 32'h2);
    check("R9 irq from set flag", {31'b0, irq}, 32'h1);
    wr(8'h0C, 32'h2); rd(8'h00, v); check("R9 toggle clears flag", v, 32'h0);
    wr(8'h0C, 32'h2); rd(8'h00, v); check("R9 toggle sets flag", v, 32'h2);
    wr(8'h08, 32'h2); rd(8'h00, v); check("R9 clear mode", v, 32'h0);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    waitCycles(3);
    rstN = 1'b1;
    waitCycles(1);
    testReset();
    testAlias();
    testDir();
    testHold();
    testPrescale();
    testMatchIrq();
    testReload();
    testStop();
    testReadOnly();
    testWrap();
    testFlagModes();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule